// File: doc/BRIEF.md
# Byte Memory Transfer Engine

This block copies words between an external byte-wide memory and the on-chip program or data memory while the processor keeps executing, or, on request, while the processor is held. Software sets up the on-chip word address, the external byte address (a page number joined to an offset), the direction, the word format and the wait-state count. Writing a nonzero word count then launches the transfer. The count register falls by one after every word and reads back as live progress. When it reaches zero, the engine raises a one-cycle interrupt.

Each word takes one, two or three byte accesses on the external side, with the most significant byte first. Every byte access is stretched by the programmed wait states. The assembled word moves to or from on-chip memory in a single stolen cycle. A pending processor access to the external bus always goes ahead of a new byte access. When the hold option is set, the processor is held for the whole transfer and then told to restart from address 0. Out of reset, the engine loads 32 program words from byte address 0 with the processor held.

Top module: `bdma_engine`

## Requirements
- R1: Out of reset the count reads 32, the format is 0, the direction is external-to-internal, all addresses are 0 and the hold option is set. The engine is busy and holds the processor. It then loads 32 three-byte program words from byte address 0 into program addresses 0 to 31 and ends with an interrupt and a restart pulse.
- R2: A write of zero to the count register (select 4) while idle starts nothing. Busy stays low, no byte access occurs and the count stays 0.
- R3: A nonzero count write while idle starts a transfer. The count drops by exactly one after each word. When it reaches 0 the engine goes idle and pulses the interrupt output for one cycle, with the count reading 0.
- R4: The external byte address is the page (select 2, 8 bits) placed above the offset (select 1, 14 bits), 22 bits in all. It advances by one per byte access and carries from the offset into the page.
- R5: Format 0 moves 24-bit program-memory words as three bytes. Format 1 moves 16-bit data-memory words as two bytes. In both formats the most significant byte is transferred first.
- R6: Format 2 moves one byte per data word into bits 7:0, and format 3 moves one byte into bits 15:8. In both, the other bits of the word are written as zero.
- R7: With a wait count W (control bits 6:4), every byte access keeps the external request high for exactly W+1 cycles.
- R8: Each word uses exactly one on-chip memory cycle, and the on-chip request is never high for two cycles in a row.
- R9: While the processor's external-access request is high, no new byte access begins and the count does not move. The transfer continues once the request drops.
- R10: With the hold option (control bit 3) set, the processor-hold output is high for the whole transfer, and a one-cycle restart pulse comes with the interrupt. With the option clear, neither the hold nor the restart pulse appears.
- R11: The direction bit (control bit 0) set to 1 reads on-chip words and writes their bytes to external memory. Format 0 sends bits 23:16, 15:8 and 7:0. Format 1 sends bits 15:8 and 7:0. Format 2 sends bits 7:0 and format 3 sends bits 15:8.
- R12: While a transfer is running, writes to any setup register, including the count, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 3 | Register select: 0 on-chip address, 1 offset, 2 page, 3 control, 4 count |
| cfg_wdata | input | 16 | Setup write data; control is {waits[6:4], hold[3], format[2:1], dir[0]} |
| cpu_ext_req | input | 1 | Processor wants the external bus this cycle |
| ext_req_o | output | 1 | Byte access in progress |
| ext_we_o | output | 1 | Byte access is a write |
| ext_addr_o | output | 22 | External byte address {page, offset} |
| ext_wdata_o | output | 8 | Byte written to external memory |
| ext_rdata_i | input | 8 | Byte read from external memory, sampled in the last cycle of an access |
| mem_req_o | output | 1 | Stolen on-chip memory cycle |
| mem_we_o | output | 1 | On-chip cycle is a write |
| mem_pm_o | output | 1 | 1 selects program memory, 0 data memory |
| mem_addr_o | output | 14 | On-chip word address |
| mem_wdata_o | output | 24 | Word written on chip; data words use bits 15:0 |
| mem_rdata_i | input | 24 | Word read on chip, valid in the same cycle |
| count_o | output | 14 | Words still to transfer |
| busy_o | output | 1 | Transfer running |
| irq_o | output | 1 | One-cycle pulse when the count reaches zero |
| hold_cpu_o | output | 1 | Holds the processor during a held transfer |
| restart_o | output | 1 | One-cycle pulse: restart the processor at address 0 |

## Verification
If the byte index or the packing register is corrupted, whole words land in on-chip memory with their bytes rotated or with nonzero fill bits. This is visible in the first word, one stolen cycle after its last byte. A wrong address counter shows up at once on the external address pins and in the data pattern, because every external byte value depends on all 22 address bits, so a missed page carry corrupts the next byte. A count or state error appears as a missing, early or doubled interrupt, or as a run of bytes and stolen cycles that does not match the programmed count.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

   localparam int PM_W   = 24;
   localparam int DM_W   = 16;
   localparam int BYTE_W = 8;

   localparam logic [2:0] SEL_IADDR  = 3'd0;
   localparam logic [2:0] SEL_OFFSET = 3'd1;
   localparam logic [2:0] SEL_PAGE   = 3'd2;
   localparam logic [2:0] SEL_CTRL   = 3'd3;
   localparam logic [2:0] SEL_COUNT  = 3'd4;

   typedef enum logic [1:0] {
      FMT_PM24 = 2'd0,
      FMT_DM16 = 2'd1,
      FMT_LO8  = 2'd2,
      FMT_HI8  = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_BYTES,
      ST_STEAL
   } state_e;

   function automatic logic [1:0] last_idx(input fmt_e f);
      case (f)
         FMT_PM24: return 2'd2;
         FMT_DM16: return 2'd1;
         default:  return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
   import bdma_pkg::*;
#(
   parameter int IADDR_W    = 14,
   parameter int OFF_W      = 14,
   parameter int PAGE_W     = 8,
   parameter int CNT_W      = 14,
   parameter int WAIT_W     = 3,
   parameter int BOOT_LOAD  = 1,
   parameter int BOOT_COUNT = 32,
   parameter int BOOT_WAITS = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_sel,
   input  logic [15:0]               cfg_wdata,
   input  logic                      busy,
   input  logic                      byte_adv,
   input  logic                      word_done,
   output logic [IADDR_W-1:0]        iaddr,
   output logic [OFF_W+PAGE_W-1:0]   eaddr,
   output fmt_e                      fmt,
   output logic                      dir,
   output logic                      ctx,
   output logic [WAIT_W-1:0]         waits,
   output logic [CNT_W-1:0]          count,
   output logic                      start
);

   localparam int EADDR_W = OFF_W + PAGE_W;

   logic             wr_ok;
   logic [CNT_W-1:0] cnt_rst;

   generate
      if (BOOT_LOAD != 0) begin : g_boot
         assign cnt_rst = CNT_W'(BOOT_COUNT);
      end else begin : g_noboot
         assign cnt_rst = '0;
      end
   endgenerate

   assign wr_ok = cfg_we && !busy;
   assign start = wr_ok && (cfg_sel == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iaddr <= '0;
         eaddr <= '0;
         fmt   <= FMT_PM24;
         dir   <= 1'b0;
         ctx   <= 1'b1;
         waits <= WAIT_W'(BOOT_WAITS);
         count <= cnt_rst;
      end else begin
         if (wr_ok && cfg_sel == SEL_IADDR)
            iaddr <= cfg_wdata[IADDR_W-1:0];
         else if (word_done)
            iaddr <= iaddr + 1'b1;

         if (wr_ok && cfg_sel == SEL_OFFSET)
            eaddr[OFF_W-1:0] <= cfg_wdata[OFF_W-1:0];
         else if (wr_ok && cfg_sel == SEL_PAGE)
            eaddr[EADDR_W-1:OFF_W] <= cfg_wdata[PAGE_W-1:0];
         else if (byte_adv)
            eaddr <= eaddr + 1'b1;

         if (wr_ok && cfg_sel == SEL_CTRL) begin
            dir   <= cfg_wdata[0];
            fmt   <= fmt_e'(cfg_wdata[2:1]);
            ctx   <= cfg_wdata[3];
            waits <= cfg_wdata[4 +: WAIT_W];
         end

         if (start)
            count <= cfg_wdata[CNT_W-1:0];
         else if (word_done)
            count <= count - 1'b1;
      end
   end

   // An idle engine always has nothing left to move
   a_r3_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (count == '0));

   // Setup is frozen while a transfer runs
   a_r12_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_we) |=> $stable({waits, ctx, fmt, dir}));

endmodule

// File: rtl/bdma_byte_port.sv
module bdma_byte_port #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              cpu_req,
   input  logic [WAIT_W-1:0] waits,
   output logic              ext_req,
   output logic              done
);

   logic [WAIT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_req <= 1'b0;
         left    <= '0;
      end else if (ext_req) begin
         if (left == '0)
            ext_req <= 1'b0;
         else
            left <= left - 1'b1;
      end else if (go && !cpu_req) begin
         ext_req <= 1'b1;
         left    <= waits;
      end
   end

   assign done = ext_req && (left == '0);

   logic [WAIT_W:0] seen_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_len <= '0;
      else if (ext_req)
         seen_len <= seen_len + 1'b1;
      else
         seen_len <= '0;
   end

   a_r7_access_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_req) |-> (seen_len == ({1'b0, waits} + 1'b1)));

   a_r9_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_req) |-> !$past(cpu_req));

endmodule

// File: rtl/bdma_packer.sv
module bdma_packer
   import bdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              cap,
   input  logic              shift,
   input  fmt_e              fmt,
   input  logic [PM_W-1:0]   rdata,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [BYTE_W-1:0] byte_out,
   output logic [PM_W-1:0]   word_out
);

   logic [PM_W-1:0] sreg;
   logic [PM_W-1:0] aligned;

   // Outgoing word: put its first byte in the top lane
   always_comb begin
      case (fmt)
         FMT_PM24: aligned = rdata;
         FMT_DM16: aligned = {rdata[15:0], 8'h00};
         FMT_LO8:  aligned = {rdata[7:0], 16'h0000};
         default:  aligned = {rdata[15:8], 16'h0000};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (load)
         sreg <= aligned;
      else if (cap)
         sreg <= {sreg[PM_W-BYTE_W-1:0], byte_in};
      else if (shift)
         sreg <= {sreg[PM_W-BYTE_W-1:0], 8'h00};
   end

   assign byte_out = sreg[PM_W-1 -: BYTE_W];

   // Incoming word: bytes arrive in the low lanes, most significant first
   always_comb begin
      case (fmt)
         FMT_PM24: word_out = sreg;
         FMT_DM16: word_out = {8'h00, sreg[15:0]};
         FMT_LO8:  word_out = {16'h0000, sreg[7:0]};
         default:  word_out = {8'h00, sreg[7:0], 8'h00};
      endcase
   end

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
   import bdma_pkg::*;
#(
   parameter int IADDR_W    = 14,
   parameter int OFF_W      = 14,
   parameter int PAGE_W     = 8,
   parameter int CNT_W      = 14,
   parameter int WAIT_W     = 3,
   parameter int BOOT_LOAD  = 1,
   parameter int BOOT_COUNT = 32,
   parameter int BOOT_WAITS = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [2:0]               cfg_sel,
   input  logic [15:0]              cfg_wdata,
   input  logic                     cpu_ext_req,
   output logic                     ext_req_o,
   output logic                     ext_we_o,
   output logic [OFF_W+PAGE_W-1:0]  ext_addr_o,
   output logic [7:0]               ext_wdata_o,
   input  logic [7:0]               ext_rdata_i,
   output logic                     mem_req_o,
   output logic                     mem_we_o,
   output logic                     mem_pm_o,
   output logic [IADDR_W-1:0]       mem_addr_o,
   output logic [23:0]              mem_wdata_o,
   input  logic [23:0]              mem_rdata_i,
   output logic [CNT_W-1:0]         count_o,
   output logic                     busy_o,
   output logic                     irq_o,
   output logic                     hold_cpu_o,
   output logic                     restart_o
);

   localparam int EADDR_W = OFF_W + PAGE_W;
   localparam state_e ST_RESET = (BOOT_LOAD != 0) ? ST_BYTES : ST_IDLE;

   initial begin : p_param_check
      assert (IADDR_W <= 16 && OFF_W <= 16 && PAGE_W <= 16 && CNT_W <= 16)
         else $error("setup fields must fit the 16-bit write bus");
      assert (WAIT_W >= 1 && WAIT_W + 4 <= 16)
         else $error("wait field does not fit the control word");
      assert (BOOT_LOAD == 0 || (BOOT_COUNT > 0 && BOOT_COUNT < (1 << CNT_W)))
         else $error("boot count out of range");
   end

   state_e              state;
   logic [1:0]          byte_idx;
   logic                irq_q;
   logic                rst_q;

   logic [IADDR_W-1:0]  iaddr;
   logic [EADDR_W-1:0]  eaddr;
   fmt_e                fmt;
   logic                dir;
   logic                ctx;
   logic [WAIT_W-1:0]   waits;
   logic [CNT_W-1:0]    count;
   logic                start;

   logic                port_go;
   logic                port_done;
   logic                last_byte;
   logic                last_word;
   logic                byte_adv;
   logic                word_done;
   logic [7:0]          byte_out;
   logic [23:0]         word_out;

   assign port_go   = (state == ST_BYTES);
   assign last_byte = (byte_idx == last_idx(fmt));
   assign last_word = (count == CNT_W'(1));
   assign byte_adv  = port_go && port_done;
   assign word_done = (state == ST_STEAL) || (byte_adv && last_byte && dir);

   bdma_regs #(
      .IADDR_W   (IADDR_W),
      .OFF_W     (OFF_W),
      .PAGE_W    (PAGE_W),
      .CNT_W     (CNT_W),
      .WAIT_W    (WAIT_W),
      .BOOT_LOAD (BOOT_LOAD),
      .BOOT_COUNT(BOOT_COUNT),
      .BOOT_WAITS(BOOT_WAITS)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .busy     (busy_o),
      .byte_adv (byte_adv),
      .word_done(word_done),
      .iaddr    (iaddr),
      .eaddr    (eaddr),
      .fmt      (fmt),
      .dir      (dir),
      .ctx      (ctx),
      .waits    (waits),
      .count    (count),
      .start    (start)
   );

   bdma_byte_port #(
      .WAIT_W(WAIT_W)
   ) i_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (port_go),
      .cpu_req(cpu_ext_req),
      .waits  (waits),
      .ext_req(ext_req_o),
      .done   (port_done)
   );

   bdma_packer i_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (state == ST_FETCH),
      .cap     (byte_adv && !dir),
      .shift   (byte_adv && dir),
      .fmt     (fmt),
      .rdata   (mem_rdata_i),
      .byte_in (ext_rdata_i),
      .byte_out(byte_out),
      .word_out(word_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RESET;
         byte_idx <= '0;
         irq_q    <= 1'b0;
         rst_q    <= 1'b0;
      end else begin
         irq_q <= word_done && last_word;
         rst_q <= word_done && last_word && ctx;
         case (state)
            ST_IDLE: begin
               byte_idx <= '0;
               if (start)
                  state <= dir ? ST_FETCH : ST_BYTES;
            end
            ST_FETCH: state <= ST_BYTES;
            ST_BYTES: begin
               if (port_done) begin
                  if (last_byte) begin
                     byte_idx <= '0;
                     if (!dir)
                        state <= ST_STEAL;
                     else if (last_word)
                        state <= ST_IDLE;
                     else
                        state <= ST_FETCH;
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                  end
               end
            end
            default: state <= last_word ? ST_IDLE : ST_BYTES;
         endcase
      end
   end

   assign busy_o      = (state != ST_IDLE);
   assign hold_cpu_o  = busy_o && ctx;
   assign irq_o       = irq_q;
   assign restart_o   = rst_q;
   assign count_o     = count;
   assign ext_we_o    = dir;
   assign ext_addr_o  = eaddr;
   assign ext_wdata_o = byte_out;
   assign mem_req_o   = (state == ST_FETCH) || (state == ST_STEAL);
   assign mem_we_o    = (state == ST_STEAL);
   assign mem_pm_o    = (fmt == FMT_PM24);
   assign mem_addr_o  = iaddr;
   assign mem_wdata_o = word_out;

   a_r3_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (count_o == '0) && !busy_o);

   a_r8_single_steal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   a_r10_restart_held: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> $past(hold_cpu_o));

   a_r2_no_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> !$rose(ext_req_o));

endmodule

// File: tb/test_bdma_engine.sv
`timescale 1ns/1ps
module test_bdma_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        cpu_ext_req = 1'b0;
   logic        ext_req, ext_we;
   logic [21:0] ext_addr;
   logic [7:0]  ext_wdata, ext_rdata;
   logic        mem_req, mem_we, mem_pm;
   logic [13:0] mem_addr;
   logic [23:0] mem_wdata, mem_rdata;
   logic [13:0] count;
   logic        busy, irq, hold_cpu, restart;

   always #10 clk = ~clk;

   bdma_engine i_bdma_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cpu_ext_req(cpu_ext_req), .ext_req_o(ext_req), .ext_we_o(ext_we), .ext_addr_o(ext_addr),
      .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_pm_o(mem_pm), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .count_o(count), .busy_o(busy), .irq_o(irq), .hold_cpu_o(hold_cpu), .restart_o(restart)
   );

   // ---------------- memory models ----------------
   logic [23:0] pm [256];
   logic [15:0] dm [256];
   logic [7:0]  xmem [int];

   function automatic logic [7:0] pat(input logic [21:0] a);
      return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
   endfunction

   assign ext_rdata = pat(ext_addr);
   assign mem_rdata = mem_pm ? pm[mem_addr[7:0]] : {8'h00, dm[mem_addr[7:0]]};

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         if (mem_pm) pm[mem_addr[7:0]] <= mem_wdata;
         else        dm[mem_addr[7:0]] <= mem_wdata[15:0];
      end
      if (ext_req && ext_we) xmem[int'(ext_addr)] = ext_wdata;
   end

   // ---------------- port monitor ----------------
   int run_len = 0, run_min = 0, run_max = 0, run_cnt = 0;
   int steal_cnt = 0, irq_cnt = 0, restart_cnt = 0;
   bit hold_seen = 1'b0;

   always @(posedge clk) begin
      if (ext_req) run_len++;
      else if (run_len != 0) begin
         if (run_cnt == 0 || run_len < run_min) run_min = run_len;
         if (run_len > run_max) run_max = run_len;
         run_cnt++;
         run_len = 0;
      end
      if (mem_req) steal_cnt++;
      if (irq) irq_cnt++;
      if (restart) restart_cnt++;
      if (hold_cpu) hold_seen = 1'b1;
   end

   task automatic clr_stats();
      run_min = 0; run_max = 0; run_cnt = 0;
      steal_cnt = 0; irq_cnt = 0; restart_cnt = 0; hold_seen = 1'b0;
   endtask

   // ---------------- checking ----------------
   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_irq(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (irq_cnt != 0) begin ok = 1'b1; break; end
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic int nbytes(input logic [1:0] f);
      return (f == 2'd0) ? 3 : (f == 2'd1) ? 2 : 1;
   endfunction

   typedef struct packed {
      logic        dir;
      logic [1:0]  fmt;
      logic        ctx;
      logic [2:0]  w;
      logic [7:0]  page;
      logic [13:0] off;
      logic [13:0] ia;
      logic [13:0] cnt;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd1, 1'b0, 3'd0, 8'h02, 14'h0010, 14'h020, 14'd5},
      '{1'b0, 2'd2, 1'b1, 3'd2, 8'h05, 14'h3FFE, 14'h040, 14'd4},
      '{1'b0, 2'd3, 1'b0, 3'd1, 8'h01, 14'h0100, 14'h050, 14'd3},
      '{1'b0, 2'd0, 1'b0, 3'd5, 8'h03, 14'h3FFC, 14'h080, 14'd3},
      '{1'b1, 2'd1, 1'b0, 3'd0, 8'h09, 14'h3FFF, 14'h020, 14'd3},
      '{1'b1, 2'd0, 1'b1, 3'd1, 8'h10, 14'h0000, 14'h000, 14'd2},
      '{1'b1, 2'd3, 1'b0, 3'd0, 8'h11, 14'h0005, 14'h050, 14'd2},
      '{1'b1, 2'd2, 1'b0, 3'd3, 8'h12, 14'h0009, 14'h040, 14'd2}
   };

   // Compare memory against the transfer a vector describes; returns mismatches
   function automatic int data_errs(input vec_t v);
      int bad = 0;
      int nb = nbytes(v.fmt);
      logic [21:0] base = {v.page, v.off};
      for (int j = 0; j < int'(v.cnt); j++) begin
         logic [7:0] idx = 8'(v.ia + 14'(j));
         logic [7:0] b [3];
         logic [23:0] word;
         for (int k = 0; k < nb; k++) begin
            logic [21:0] a = base + 22'(j * nb + k);
            if (!v.dir) b[k] = pat(a);
         end
         if (!v.dir) begin
            case (v.fmt)
               2'd0: if (pm[idx] !== {b[0], b[1], b[2]}) bad++;
               2'd1: if (dm[idx] !== {b[0], b[1]}) bad++;
               2'd2: if (dm[idx] !== {8'h00, b[0]}) bad++;
               default: if (dm[idx] !== {b[0], 8'h00}) bad++;
            endcase
         end else begin
            word = (v.fmt == 2'd0) ? pm[idx] : {8'h00, dm[idx]};
            case (v.fmt)
               2'd0: begin b[0] = word[23:16]; b[1] = word[15:8]; b[2] = word[7:0]; end
               2'd1: begin b[0] = word[15:8]; b[1] = word[7:0]; end
               2'd2: b[0] = word[7:0];
               default: b[0] = word[15:8];
            endcase
            for (int k = 0; k < nb; k++) begin
               int a = int'(base + 22'(j * nb + k));
               if (!xmem.exists(a)) bad++;
               else if (xmem[a] !== b[k]) bad++;
            end
         end
      end
      return bad;
   endfunction

   function automatic bit crosses(input vec_t v);
      return (int'(v.off) + int'(v.cnt) * nbytes(v.fmt)) > 16384;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #3000000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      bit ok;
      int bad;
      for (int i = 0; i < 256; i++) begin
         pm[i] = 24'hC30000 ^ 24'(i * 24'h010203);
         dm[i] = 16'h9100 ^ 16'(i * 16'h0107);
      end

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(count == 14'd32, "R1 reset count", count, 32);
      chk(busy == 1'b1, "R1 reset busy", busy, 1);
      chk(hold_cpu == 1'b1, "R1 reset hold", hold_cpu, 1);
      chk(ext_req == 1'b0 && irq == 1'b0, "R1 reset quiet", {ext_req, irq}, 0);
      clr_stats();
      rst_n = 1'b1;

      // R1 boot load
      wait_irq(ok);
      chk(ok, "R1 boot finished", ok, 1);
      bad = 0;
      for (int k = 0; k < 32; k++)
         if (pm[k] !== {pat(22'(3*k)), pat(22'(3*k+1)), pat(22'(3*k+2))}) bad++;
      chk(bad == 0, "R1 boot data", bad, 0);
      chk(steal_cnt == 32, "R8 boot steals", steal_cnt, 32);
      chk(run_cnt == 96 && run_min == 4 && run_max == 4, "R7 boot byte length", run_max, 4);
      chk(irq_cnt == 1 && count == 0 && !busy, "R3 boot end", irq_cnt, 1);
      chk(restart_cnt == 1 && !hold_cpu, "R10 boot restart", restart_cnt, 1);

      // Vector walk
      for (int n = 0; n < NV; n++) begin
         vec_t v = VEC[n];
         wr(3'd0, 16'(v.ia));
         wr(3'd1, 16'(v.off));
         wr(3'd2, 16'(v.page));
         wr(3'd3, {9'd0, v.w, v.ctx, v.fmt, v.dir});
         @(negedge clk);
         clr_stats();
         wr(3'd4, 16'(v.cnt));
         wait_irq(ok);
         chk(ok && irq_cnt == 1 && count == 0 && !busy, "R3 vector end", irq_cnt, 1);
         chk(steal_cnt == int'(v.cnt), "R8 steals per word", steal_cnt, int'(v.cnt));
         chk(run_cnt == int'(v.cnt) * nbytes(v.fmt) && run_min == int'(v.w) + 1 &&
             run_max == int'(v.w) + 1, "R7 wait states", run_max, int'(v.w) + 1);
         chk(hold_seen == v.ctx && restart_cnt == int'(v.ctx), "R10 hold option",
             {hold_seen, 4'(restart_cnt)}, {v.ctx, 4'(v.ctx)});
         bad = data_errs(v);
         if (v.dir)              chk(bad == 0, "R11 outbound bytes", bad, 0);
         else if (v.fmt < 2'd2)  chk(bad == 0, "R5 packed words", bad, 0);
         else                    chk(bad == 0, "R6 zero fill", bad, 0);
         if (crosses(v))         chk(bad == 0, "R4 page carry", bad, 0);
      end

      // R2: zero count starts nothing
      @(negedge clk);
      clr_stats();
      wr(3'd4, 16'd0);
      repeat (10) @(negedge clk);
      chk(!busy && run_cnt == 0 && !ext_req && count == 0, "R2 zero count", {busy, 8'(run_cnt)}, 0);

      // R12 writes ignored while busy; R3 live count
      wr(3'd0, 16'h0A0);
      wr(3'd1, 16'h0000);
      wr(3'd2, 16'h0020);
      wr(3'd3, {9'd0, 3'd7, 1'b0, 2'd1, 1'b0});
      @(negedge clk);
      clr_stats();
      wr(3'd4, 16'd3);
      wr(3'd2, 16'h0033);
      wr(3'd4, 16'd100);
      wr(3'd3, {9'd0, 3'd0, 1'b1, 2'd2, 1'b1});
      chk(count == 14'd3, "R12 count locked", count, 3);
      for (int i = 0; i < 200 && steal_cnt == 0; i++) @(negedge clk);
      chk(count == 14'd2, "R3 live decrement", count, 2);
      wait_irq(ok);
      bad = data_errs('{1'b0, 2'd1, 1'b0, 3'd7, 8'h20, 14'h0000, 14'h0A0, 14'd3});
      chk(ok && bad == 0 && steal_cnt == 3, "R12 setup unchanged", bad, 0);
      chk(restart_cnt == 0 && !hold_seen, "R12 hold bit unchanged", restart_cnt, 0);

      // R9 processor access has priority
      wr(3'd0, 16'h0C0);
      wr(3'd1, 16'h0100);
      wr(3'd2, 16'h0040);
      wr(3'd3, {9'd0, 3'd1, 1'b0, 2'd2, 1'b0});
      @(negedge clk);
      cpu_ext_req = 1'b1;
      clr_stats();
      wr(3'd4, 16'd2);
      repeat (40) @(negedge clk);
      chk(run_cnt == 0 && run_len == 0 && !ext_req, "R9 no access while blocked", run_len, 0);
      chk(count == 14'd2 && busy, "R9 count held", count, 2);
      cpu_ext_req = 1'b0;
      wait_irq(ok);
      bad = data_errs('{1'b0, 2'd2, 1'b0, 3'd1, 8'h40, 14'h0100, 14'h0C0, 14'd2});
      chk(ok && bad == 0, "R9 resumes after release", bad, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule